// File: doc/BRIEF.md
# Stateful Memory Access Reference Monitor

This block stands between two bus masters and a set of shared memory-mapped resources. It judges every access request against a fixed sharing policy. A request carries a master identifier, a two-bit operation code and a 32-bit address. The address is compared with ten inclusive windows, all at the same time. The master, the operation and the resulting hit vector then feed a single case decode, which is qualified by the current policy state. The block registers a grant or deny verdict one cycle after the request and updates the policy state on the same clock edge.

Each master always keeps its own private resources, and both masters share a debug window. The crypto engine's first region and its control word belong to at most one master at a time. Ownership is taken by writing the "take" control word while the engine is unowned, and it is released when the owner writes the "drop" control word. Any request that the policy does not allow sends the monitor into a locked state. In that state every later request is denied until a synchronous reset.

Top module: `refmon_top`

## Requirements
- R1: A request presented with `req_valid` high gets `resp_valid` high exactly one cycle later, with its verdict on `resp_grant`. A cycle with `req_valid` low gives `resp_valid` and `resp_grant` low in the next cycle and leaves the policy state unchanged.
- R2: In every unlocked state, master 0 is granted read (op 2'b10), write (2'b01) and read-write (2'b11) access to serial 0x40600000–0x4060FFFF and DRAM1 0x24000000–0x24777777. Master 1 gets the same on Ethernet 0x40C00000–0x40C0FFFF and DRAM2 0x24800000–0x24FFFFFF. Both masters get it on debug 0x41400000–0x4140FFFF.
- R3: A master that touches the other master's private serial, Ethernet or DRAM window is denied, and the monitor locks.
- R4: While the crypto engine is unowned, any access to crypto region 1 (0x28000000–0x28000777) is denied and locks the monitor. This includes its crypto control word 0x28000000–0x28000003 and reads of either trigger word.
- R5: While the engine is unowned, a write (op bit 0 set) by a master to the take word 0x28000004–0x28000007 is granted and makes that master the owner.
- R6: The owner is granted any access to crypto region 1, including the crypto control word. The non-owner is denied and the monitor locks. Crypto region 2 (0x28000800–0x28000FFF) is denied to both masters in every state.
- R7: A write by the owner to the drop word 0x28000008–0x2800000F is granted and returns the engine to unowned. A drop write while unowned, or a trigger write by the non-owner, is denied and locks. Ownership never passes directly from one master to the other.
- R8: Operation code 2'b00 is denied and locks the monitor.
- R9: An address inside no window, including the gap 0x28000778–0x280007FF, is denied and locks the monitor.
- R10: Once locked, the monitor denies every request until `rst` is asserted. Reset clears both response outputs and returns the engine to unowned.
- R11: Window bounds are inclusive. The first and last address of a window are treated as inside it, and the addresses just outside are treated as outside it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_master | input | 1 | Requesting master: 0 or 1 |
| req_op | input | 2 | Operation: bit 1 read, bit 0 write |
| req_addr | input | 32 | Request address |
| resp_valid | output | 1 | Verdict valid, one cycle after the request |
| resp_grant | output | 1 | 1 = granted, 0 = denied |

## Verification
The hardest situation to reach is a probe made in a particular ownership state. A single denial locks the monitor, and the lock can only be cleared by reset. The bench therefore resets before every probe and replays the take write that leads to the wanted state. It then issues one probe at each window edge and one address beyond each edge, for every master, every operation code and every ownership state. After the probe it sends a debug read to find out whether the monitor locked, and a crypto-control read to find out who owns the engine, so the hidden state is read back through the ports alone.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

    localparam int ADDR_W     = 32;
    localparam int NUM_RANGES = 10;
    localparam int OP_W       = 2;

    // Window indices into the hit vector
    localparam int RG_DEBUG     = 0;
    localparam int RG_CRYPTO1   = 1;
    localparam int RG_CRYPTO2   = 2;
    localparam int RG_DRAM1     = 3;
    localparam int RG_DRAM2     = 4;
    localparam int RG_SERIAL    = 5;
    localparam int RG_ETH       = 6;
    localparam int RG_TAKE      = 7;
    localparam int RG_DROP      = 8;
    localparam int RG_CRYPTO_CT = 9;

    typedef logic [NUM_RANGES-1:0] hit_t;
    typedef logic [ADDR_W-1:0]     addr_t;
    typedef logic [OP_W-1:0]       op_t;

    localparam op_t OP_NONE = 2'b00;
    localparam op_t OP_WR   = 2'b01;
    localparam op_t OP_RD   = 2'b10;
    localparam op_t OP_RW   = 2'b11;

    typedef enum logic [1:0] {
        POL_FREE   = 2'd0,
        POL_OWN_A  = 2'd1,
        POL_OWN_B  = 2'd2,
        POL_LOCKED = 2'd3
    } pol_state_t;

    typedef struct packed {
        logic  master;
        op_t   op;
        addr_t addr;
    } req_t;

    typedef struct packed {
        logic       allow;
        pol_state_t next;
    } verdict_t;

    // Hit patterns a legal address can produce
    localparam hit_t HIT_DEBUG   = hit_t'(1) << RG_DEBUG;
    localparam hit_t HIT_SERIAL  = hit_t'(1) << RG_SERIAL;
    localparam hit_t HIT_ETH     = hit_t'(1) << RG_ETH;
    localparam hit_t HIT_DRAM1   = hit_t'(1) << RG_DRAM1;
    localparam hit_t HIT_DRAM2   = hit_t'(1) << RG_DRAM2;
    localparam hit_t HIT_CRYPTO1 = hit_t'(1) << RG_CRYPTO1;
    localparam hit_t HIT_TAKE    = HIT_CRYPTO1 | (hit_t'(1) << RG_TAKE);
    localparam hit_t HIT_DROP    = HIT_CRYPTO1 | (hit_t'(1) << RG_DROP);
    localparam hit_t HIT_CTL     = HIT_CRYPTO1 | (hit_t'(1) << RG_CRYPTO_CT);

    // Windows that never overlap one another
    localparam hit_t DISJOINT_MASK = ~((hit_t'(1) << RG_TAKE) |
                                       (hit_t'(1) << RG_DROP) |
                                       (hit_t'(1) << RG_CRYPTO_CT));

    function automatic addr_t range_lo(input int idx);
        case (idx)
            RG_DEBUG:     range_lo = 32'h4140_0000;
            RG_CRYPTO1:   range_lo = 32'h2800_0000;
            RG_CRYPTO2:   range_lo = 32'h2800_0800;
            RG_DRAM1:     range_lo = 32'h2400_0000;
            RG_DRAM2:     range_lo = 32'h2480_0000;
            RG_SERIAL:    range_lo = 32'h4060_0000;
            RG_ETH:       range_lo = 32'h40C0_0000;
            RG_TAKE:      range_lo = 32'h2800_0004;
            RG_DROP:      range_lo = 32'h2800_0008;
            default:      range_lo = 32'h2800_0000;
        endcase
    endfunction

    function automatic addr_t range_hi(input int idx);
        case (idx)
            RG_DEBUG:     range_hi = 32'h4140_FFFF;
            RG_CRYPTO1:   range_hi = 32'h2800_0777;
            RG_CRYPTO2:   range_hi = 32'h2800_0FFF;
            RG_DRAM1:     range_hi = 32'h2477_7777;
            RG_DRAM2:     range_hi = 32'h24FF_FFFF;
            RG_SERIAL:    range_hi = 32'h4060_FFFF;
            RG_ETH:       range_hi = 32'h40C0_FFFF;
            RG_TAKE:      range_hi = 32'h2800_0007;
            RG_DROP:      range_hi = 32'h2800_000F;
            default:      range_hi = 32'h2800_0003;
        endcase
    endfunction

    function automatic logic is_owner(input pol_state_t s, input logic master);
        is_owner = (s == POL_OWN_A && !master) || (s == POL_OWN_B && master);
    endfunction

    function automatic pol_state_t own_state(input logic master);
        own_state = master ? POL_OWN_B : POL_OWN_A;
    endfunction

endpackage

// File: rtl/refmon_range_match.sv
module refmon_range_match
    import refmon_pkg::*;
#(
    parameter int N_RANGES = NUM_RANGES
) (
    input  addr_t               addr_i,
    output logic [N_RANGES-1:0] hit_o
);

    // One comparator pair per window, all evaluated at once
    for (genvar gi = 0; gi < N_RANGES; gi++) begin : g_win
        localparam addr_t LO = range_lo(gi);
        localparam addr_t HI = range_hi(gi);
        assign hit_o[gi] = (addr_i >= LO) && (addr_i <= HI);
    end

    // R11: an address can land in at most one of the non-nested windows
    always_comb begin
        a_r11_disjoint_windows: assert ($onehot0(hit_o & N_RANGES'(DISJOINT_MASK)));
    end

endmodule

// File: rtl/refmon_rule_decode.sv
module refmon_rule_decode
    import refmon_pkg::*;
(
    input  pol_state_t state_i,
    input  logic       master_i,
    input  op_t        op_i,
    input  hit_t       hit_i,
    output verdict_t   verdict_o
);

    logic owner;
    assign owner = is_owner(state_i, master_i);

    always_comb begin
        verdict_o.allow = 1'b0;
        verdict_o.next  = state_i;
        if (state_i != POL_LOCKED && op_i != OP_NONE) begin
            casez ({master_i, op_i, hit_i})
                // Shared and private base rights
                {1'b?, 2'b??, HIT_DEBUG},
                {1'b0, 2'b??, HIT_SERIAL},
                {1'b0, 2'b??, HIT_DRAM1},
                {1'b1, 2'b??, HIT_ETH},
                {1'b1, 2'b??, HIT_DRAM2}: verdict_o.allow = 1'b1;
                // Take word written
                {1'b?, 2'b?1, HIT_TAKE}: begin
                    if (state_i == POL_FREE) begin
                        verdict_o.allow = 1'b1;
                        verdict_o.next  = own_state(master_i);
                    end else begin
                        verdict_o.allow = owner;
                    end
                end
                // Drop word written
                {1'b?, 2'b?1, HIT_DROP}: begin
                    if (owner) begin
                        verdict_o.allow = 1'b1;
                        verdict_o.next  = POL_FREE;
                    end
                end
                // Plain crypto region access, owner only
                {1'b?, 2'b10, HIT_TAKE},
                {1'b?, 2'b10, HIT_DROP},
                {1'b?, 2'b??, HIT_CTL},
                {1'b?, 2'b??, HIT_CRYPTO1}: verdict_o.allow = owner;
                default: verdict_o.allow = 1'b0;
            endcase
        end
        if (!verdict_o.allow) begin
            verdict_o.next = POL_LOCKED;
        end
    end

endmodule

// File: rtl/refmon_state_reg.sv
module refmon_state_reg
    import refmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid_i,
    input  verdict_t   verdict_i,
    output pol_state_t state_o,
    output logic       resp_valid_o,
    output logic       resp_grant_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_o      <= POL_FREE;
            resp_valid_o <= 1'b0;
            resp_grant_o <= 1'b0;
        end else begin
            resp_valid_o <= req_valid_i;
            resp_grant_o <= req_valid_i && verdict_i.allow;
            if (req_valid_i) begin
                state_o <= verdict_i.next;
            end
        end
    end

    a_r1_verdict_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> resp_valid_o);
    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> (!resp_valid_o && !resp_grant_o));
    a_r1_idle_holds_state: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> $stable(state_o));
    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        (state_o == POL_LOCKED) |=> (state_o == POL_LOCKED));
    a_r10_lock_denies: assert property (@(posedge clk) disable iff (rst)
        (state_o == POL_LOCKED && req_valid_i) |=> !resp_grant_o);
    a_r7_no_handover_a: assert property (@(posedge clk) disable iff (rst)
        (state_o == POL_OWN_A) |=> (state_o != POL_OWN_B));
    a_r7_no_handover_b: assert property (@(posedge clk) disable iff (rst)
        (state_o == POL_OWN_B) |=> (state_o != POL_OWN_A));

endmodule

// File: rtl/refmon_top.sv
module refmon_top
    import refmon_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_master,
    input  logic [1:0]  req_op,
    input  logic [31:0] req_addr,
    output logic        resp_valid,
    output logic        resp_grant
);

    req_t       req;
    hit_t       hit;
    verdict_t   verdict;
    pol_state_t state;

    assign req = '{master: req_master, op: req_op, addr: req_addr};

    refmon_range_match #(.N_RANGES(NUM_RANGES)) u_match (
        .addr_i (req.addr),
        .hit_o  (hit)
    );

    refmon_rule_decode u_decode (
        .state_i   (state),
        .master_i  (req.master),
        .op_i      (req.op),
        .hit_i     (hit),
        .verdict_o (verdict)
    );

    refmon_state_reg u_state (
        .clk          (clk),
        .rst          (rst),
        .req_valid_i  (req_valid),
        .verdict_i    (verdict),
        .state_o      (state),
        .resp_valid_o (resp_valid),
        .resp_grant_o (resp_grant)
    );

    // R5: a grant of a take write while free leaves an owner behind
    a_r5_take_claims: assert property (@(posedge clk) disable iff (rst)
        (req_valid && state == POL_FREE && verdict.next != POL_FREE &&
         verdict.next != POL_LOCKED) |=> (state != POL_FREE && resp_grant));

endmodule

// File: tb/tb_refmon_top.sv
module tb_refmon_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_master = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] req_addr = '0;
    logic        resp_valid;
    logic        resp_grant;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    refmon_top dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_master(req_master),
        .req_op(req_op), .req_addr(req_addr),
        .resp_valid(resp_valid), .resp_grant(resp_grant)
    );

    logic [31:0] win_lo [10];
    logic [31:0] win_hi [10];

    function automatic bit inside_w(input logic [31:0] a, input logic [31:0] lo, input logic [31:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    // Policy model: state 0 free, 1 master0 owns, 2 master1 owns, 3 locked
    task automatic model(input int st, input bit m, input logic [1:0] op, input logic [31:0] a,
                         output bit ok, output int nst, output string tag);
        bit own;
        own = (st == 1 && !m) || (st == 2 && m);
        ok = 1'b0; nst = st; tag = "R9";
        if (st == 3) tag = "R10";
        else if (op == 2'b00) tag = "R8";
        else if (inside_w(a, 32'h4140_0000, 32'h4140_FFFF)) begin ok = 1; tag = "R2"; end
        else if (inside_w(a, 32'h4060_0000, 32'h4060_FFFF) || inside_w(a, 32'h2400_0000, 32'h2477_7777)) begin
            ok = !m; tag = m ? "R3" : "R2";
        end
        else if (inside_w(a, 32'h40C0_0000, 32'h40C0_FFFF) || inside_w(a, 32'h2480_0000, 32'h24FF_FFFF)) begin
            ok = m; tag = m ? "R2" : "R3";
        end
        else if (inside_w(a, 32'h2800_0004, 32'h2800_0007) && op[0]) begin
            tag = "R5";
            if (st == 0) begin ok = 1; nst = m ? 2 : 1; end
            else ok = own;
        end
        else if (inside_w(a, 32'h2800_0008, 32'h2800_000F) && op[0]) begin
            tag = "R7";
            if (own) begin ok = 1; nst = 0; end
        end
        else if (inside_w(a, 32'h2800_0000, 32'h2800_0777)) begin
            ok = own; tag = (st == 0) ? "R4" : "R6";
        end
        else if (inside_w(a, 32'h2800_0800, 32'h2800_0FFF)) tag = "R6";
        if (!ok) nst = 3;
    endtask

    task automatic check(input string tag, input logic got, input logic exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, got, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge with the verdict visible
    task automatic send(input bit m, input logic [1:0] op, input logic [31:0] a);
        req_valid = 1'b1; req_master = m; req_op = op; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic setup(input int st);
        do_reset();
        if (st == 1) send(1'b0, 2'b01, 32'h2800_0004);
        if (st == 2) send(1'b1, 2'b01, 32'h2800_0004);
    endtask

    task automatic probe(input int st, input bit m, input logic [1:0] op, input logic [31:0] a);
        bit ok; int nst; string tag;
        setup(st);
        model(st, m, op, a, ok, nst, tag);
        send(m, op, a);
        check("R1", resp_valid, 1'b1, $sformatf("valid st=%0d a=%h", st, a));
        check(tag, resp_grant, ok, $sformatf("R11 grant st=%0d m=%0d op=%b a=%h", st, m, op, a));
        @(negedge clk);
        check("R1", resp_valid, 1'b0, "idle cycle");
        send(1'b0, 2'b10, 32'h4140_0000);
        check("R10", resp_grant, nst != 3, $sformatf("lock after a=%h", a));
        if (nst != 3) begin
            send(1'b0, 2'b10, 32'h2800_0000);
            check("R5", resp_grant, nst == 1, $sformatf("owner after a=%h", a));
        end
    endtask

    initial begin
        win_lo[0] = 32'h4140_0000; win_hi[0] = 32'h4140_FFFF;
        win_lo[1] = 32'h2800_0000; win_hi[1] = 32'h2800_0777;
        win_lo[2] = 32'h2800_0800; win_hi[2] = 32'h2800_0FFF;
        win_lo[3] = 32'h2400_0000; win_hi[3] = 32'h2477_7777;
        win_lo[4] = 32'h2480_0000; win_hi[4] = 32'h24FF_FFFF;
        win_lo[5] = 32'h4060_0000; win_hi[5] = 32'h4060_FFFF;
        win_lo[6] = 32'h40C0_0000; win_hi[6] = 32'h40C0_FFFF;
        win_lo[7] = 32'h2800_0004; win_hi[7] = 32'h2800_0007;
        win_lo[8] = 32'h2800_0008; win_hi[8] = 32'h2800_000F;
        win_lo[9] = 32'h2800_0000; win_hi[9] = 32'h2800_0003;

        @(negedge clk);
        do_reset();
        check("R10", resp_valid, 1'b0, "reset valid");
        check("R10", resp_grant, 1'b0, "reset grant");

        // R11 edge sweep over states, masters, opcodes and windows
        for (int st = 0; st < 3; st++)
            for (int m = 0; m < 2; m++)
                for (int op = 0; op < 4; op++)
                    for (int w = 0; w < 10; w++) begin
                        probe(st, m[0], op[1:0], win_lo[w] - 32'd1);
                        probe(st, m[0], op[1:0], win_lo[w]);
                        probe(st, m[0], op[1:0], win_hi[w]);
                        probe(st, m[0], op[1:0], win_hi[w] + 32'd1);
                    end

        // R9 gap inside the crypto block
        probe(0, 1'b0, 2'b10, 32'h2800_0778);
        probe(1, 1'b0, 2'b11, 32'h2800_07FF);

        // R7 take, drop, take by the other master
        do_reset();
        send(1'b1, 2'b01, 32'h2800_0004); check("R5", resp_grant, 1'b1, "master1 take");
        send(1'b1, 2'b11, 32'h2800_0100); check("R6", resp_grant, 1'b1, "master1 crypto rw");
        send(1'b1, 2'b01, 32'h2800_0008); check("R7", resp_grant, 1'b1, "master1 drop");
        send(1'b0, 2'b01, 32'h2800_0004); check("R7", resp_grant, 1'b1, "master0 take after drop");
        send(1'b0, 2'b10, 32'h2800_0000); check("R6", resp_grant, 1'b1, "master0 ctl read");

        // R10 sticky lock cleared only by reset
        send(1'b1, 2'b01, 32'h2800_000C); check("R7", resp_grant, 1'b0, "non-owner drop");
        for (int k = 0; k < 4; k++) begin
            send(k[0], 2'b10, 32'h4140_0010); check("R10", resp_grant, 1'b0, "locked debug read");
        end
        do_reset();
        check("R10", resp_valid, 1'b0, "reset after lock");
        send(1'b1, 2'b10, 32'h4140_0010); check("R10", resp_grant, 1'b1, "unlocked after reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule